// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block holds the per-channel addressing state of a four-channel DMA controller. Each channel keeps a base and a working copy of a 16-bit memory address and of a 16-bit transfer count, plus a direction bit, an auto-reload bit, a mask bit and a software request bit. A host programs the channels through a byte-wide write port. A separate transfer sequencer names a channel and pulses once per byte moved. On each pulse the named channel's working address steps by one in its programmed direction and its working count drops by one.

A transfer sequence ends when the working count steps below zero, so a programmed count of N gives N+1 transfers. At that point the block raises a one-cycle terminal-count flag. The channel then either reloads its working registers from the base copies or masks itself off. The block also reports which channels may currently be served: a hardware request passes only when its mask bit is clear, and a software request always passes.

Every pin is a plain level or strobe. Writes and transfer pulses are accepted on every cycle, so there is no back-pressure. Bus strobes, the bus hold handshake and arbitration between channels live in neighbouring blocks.

Top module: `dma_chan_regs`

## Requirements
- R1: While reset is low and on the first cycle after it, `cur_addr` is 0, `tc` is 0 and `chan_en` is 0 whatever `hw_req` is. Reset sets all mask bits, clears all software requests, clears the byte pointer, and clears all addresses, counts and mode bits.
- R2: Word writes use a shared byte pointer.
  - `wr_sel` 0..3 writes the address of channel `wr_sel[1:0]`; `wr_sel` 4..7 writes the count of channel `wr_sel[1:0]`.
  - The first byte after the pointer is cleared goes to bits 7:0 and the next byte goes to bits 15:8. Each byte lands in the base and the working copy together.
  - Every address or count write toggles the pointer, and a write with `wr_sel` = 11 clears it.
- R3: A cycle with `xfer_pulse` high changes only the channel named by `xfer_sel`. Its working address becomes address+1 when the direction bit is 0 and address-1 when it is 1, wrapping modulo 65536. `cur_addr` always shows the working address of the channel named by `xfer_sel`.
- R4: Each pulse lowers the channel's working count by one. A programmed count of N yields terminal count on pulse N+1.
- R5: `tc` is high in exactly the one cycle that follows a clock edge at which a pulse found the working count at 0.
- R6: At terminal count with the auto-reload bit set, the working address and count are reloaded from the base copies instead of being stepped, and the mask bit is left as it was.
- R7: At terminal count with the auto-reload bit clear, the address still steps, the working count becomes 0xFFFF, and the channel's mask bit is set.
- R8: `chan_en[n]` is high when `hw_req[n]` is high and mask bit n is clear, or when software request n is set. The mask bits are written in two ways:
  - A write with `wr_sel` = 9 sets the mask bit of channel `wr_data[1:0]` to `wr_data[2]`.
  - A write with `wr_sel` = 12 loads all mask bits from `wr_data[3:0]`.
- R9: A write with `wr_sel` = 10 sets the software request bit of channel `wr_data[1:0]` to `wr_data[2]`. Terminal count on a channel clears that channel's software request bit.
- R10: A write with `wr_sel` = 8 sets the mode of channel `wr_data[1:0]`: `wr_data[2]` is the direction bit (1 = down) and `wr_data[3]` is the auto-reload bit. Writes with `wr_sel` 13..15 have no effect.
- R11: When a host byte write and a pulse reach the same register in the same cycle, the pulse's step or reload is applied first and the written byte then replaces its half. For mask and request bits, the terminal-count action is applied after the host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Host register select |
| wr_data | input | 8 | Host write byte |
| xfer_sel | input | 2 | Channel served by the sequencer |
| xfer_pulse | input | 1 | One transfer completed on `xfer_sel` |
| hw_req | input | 4 | Hardware request per channel |
| cur_addr | output | 16 | Working address of channel `xfer_sel` |
| tc | output | 1 | Terminal-count flag, one cycle |
| chan_en | output | 4 | Channels eligible for service |

## Verification
A wrong working address shows on `cur_addr` in the first cycle after the faulty edge, as long as the sequencer names that channel. A wrong count stays hidden until the underflow: `tc` then rises one pulse early or late, and the mask bit or reload that follows shows on `chan_en` and `cur_addr` in the same cycle. A byte pointer out of step shows only at the next word write, as swapped halves of an address. The bench therefore compares all three outputs against a behavioural model on every cycle, so each fault is caught at its first visible symptom.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 4;

  // register select codes outside the address/count window (0..7)
  localparam logic [SEL_W-1:0] SEL_MODE     = 4'd8;
  localparam logic [SEL_W-1:0] SEL_MASK_ONE = 4'd9;
  localparam logic [SEL_W-1:0] SEL_SWREQ    = 4'd10;
  localparam logic [SEL_W-1:0] SEL_PTR_CLR  = 4'd11;
  localparam logic [SEL_W-1:0] SEL_MASK_ALL = 4'd12;

  // bit positions inside a command byte
  localparam int unsigned CMD_VAL_BIT  = 2;
  localparam int unsigned MODE_DN_BIT  = 2;
  localparam int unsigned MODE_AUT_BIT = 3;

  // per-channel write strobes produced by the host decoder
  typedef struct packed {
    logic addr_lo;
    logic addr_hi;
    logic cnt_lo;
    logic cnt_hi;
    logic mode;
  } slot_wr_t;

endpackage

// File: rtl/dma_host_decode.sv
module dma_host_decode
  import dma_chan_regs_pkg::*;
#(
  parameter  int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [BYTE_W-1:0]     wr_data,
  output slot_wr_t [NCH-1:0]    slot_wr,
  output logic [NCH-1:0]        mask_set,
  output logic [NCH-1:0]        mask_clr,
  output logic [NCH-1:0]        req_set,
  output logic [NCH-1:0]        req_clr,
  output logic                  byte_ptr
);

  logic ptr_q;
  logic word_wr;
  logic mode_wr;
  logic mask_one_wr;
  logic mask_all_wr;
  logic swreq_wr;
  logic ptr_clr;

  // address/count window is select codes 0..7; bit 2 picks count
  assign word_wr     = wr_en && !wr_sel[SEL_W-1];
  assign mode_wr     = wr_en && (wr_sel == SEL_MODE);
  assign mask_one_wr = wr_en && (wr_sel == SEL_MASK_ONE);
  assign mask_all_wr = wr_en && (wr_sel == SEL_MASK_ALL);
  assign swreq_wr    = wr_en && (wr_sel == SEL_SWREQ);
  assign ptr_clr     = wr_en && (wr_sel == SEL_PTR_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
    end else if (ptr_clr) begin
      ptr_q <= 1'b0;
    end else if (word_wr) begin
      ptr_q <= ~ptr_q;
    end
  end

  assign byte_ptr = ptr_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_hit;
    logic cmd_hit;

    assign sel_hit = (wr_sel[CH_W-1:0] == CH_W'(c));
    assign cmd_hit = (wr_data[CH_W-1:0] == CH_W'(c));

    assign slot_wr[c].addr_lo = word_wr && !wr_sel[2] && sel_hit && !ptr_q;
    assign slot_wr[c].addr_hi = word_wr && !wr_sel[2] && sel_hit &&  ptr_q;
    assign slot_wr[c].cnt_lo  = word_wr &&  wr_sel[2] && sel_hit && !ptr_q;
    assign slot_wr[c].cnt_hi  = word_wr &&  wr_sel[2] && sel_hit &&  ptr_q;
    assign slot_wr[c].mode    = mode_wr && cmd_hit;

    assign mask_set[c] = (mask_one_wr && cmd_hit &&  wr_data[CMD_VAL_BIT])
                       || (mask_all_wr &&  wr_data[c]);
    assign mask_clr[c] = (mask_one_wr && cmd_hit && !wr_data[CMD_VAL_BIT])
                       || (mask_all_wr && !wr_data[c]);
    assign req_set[c]  = swreq_wr && cmd_hit &&  wr_data[CMD_VAL_BIT];
    assign req_clr[c]  = swreq_wr && cmd_hit && !wr_data[CMD_VAL_BIT];
  end

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_chan_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_wr_t          wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              tc_hit,
  output logic              tc_to_mask
);

  localparam int unsigned HI = ADDR_W - 1;
  localparam int unsigned LO = BYTE_W;

  logic [ADDR_W-1:0] base_a_q, cur_a_q, base_c_q, cur_c_q;
  logic [ADDR_W-1:0] base_a_d, cur_a_d, base_c_d, cur_c_d;
  logic              down_q, auto_q;

  assign tc_hit     = step && (cur_c_q == '0);
  assign tc_to_mask = tc_hit && !auto_q;

  always_comb begin
    base_a_d = base_a_q;
    base_c_d = base_c_q;
    cur_a_d  = cur_a_q;
    cur_c_d  = cur_c_q;

    if (step) begin
      if (tc_hit && auto_q) begin
        cur_a_d = base_a_q;
        cur_c_d = base_c_q;
      end else begin
        cur_a_d = down_q ? (cur_a_q - ADDR_W'(1)) : (cur_a_q + ADDR_W'(1));
        cur_c_d = cur_c_q - ADDR_W'(1);
      end
    end

    // host byte overrides the stepped value of the same half
    if (wr.addr_lo) begin
      cur_a_d[LO-1:0]  = wr_data;
      base_a_d[LO-1:0] = wr_data;
    end
    if (wr.addr_hi) begin
      cur_a_d[HI:LO]  = wr_data;
      base_a_d[HI:LO] = wr_data;
    end
    if (wr.cnt_lo) begin
      cur_c_d[LO-1:0]  = wr_data;
      base_c_d[LO-1:0] = wr_data;
    end
    if (wr.cnt_hi) begin
      cur_c_d[HI:LO]  = wr_data;
      base_c_d[HI:LO] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      cur_a_q  <= '0;
      base_c_q <= '0;
      cur_c_q  <= '0;
    end else begin
      base_a_q <= base_a_d;
      cur_a_q  <= cur_a_d;
      base_c_q <= base_c_d;
      cur_c_q  <= cur_c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr.mode) begin
      down_q <= wr_data[MODE_DN_BIT];
      auto_q <= wr_data[MODE_AUT_BIT];
    end
  end

  assign cur_addr = cur_a_q;

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mask_set,
  input  logic [NCH-1:0] mask_clr,
  input  logic [NCH-1:0] req_set,
  input  logic [NCH-1:0] req_clr,
  input  logic [NCH-1:0] tc_mask,
  input  logic [NCH-1:0] tc_hit,
  input  logic [NCH-1:0] hw_req,
  output logic [NCH-1:0] chan_en,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] req_q
);

  logic [NCH-1:0] mask_d, req_d;

  // host command first, terminal-count action on top
  always_comb begin
    mask_d = ((mask_q | mask_set) & ~mask_clr) | tc_mask;
    req_d  = ((req_q | req_set) & ~req_clr) & ~tc_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      req_q  <= '0;
    end else begin
      mask_q <= mask_d;
      req_q  <= req_d;
    end
  end

  assign chan_en = (hw_req & ~mask_q) | req_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter  int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CH_W-1:0]   xfer_sel,
  input  logic              xfer_pulse,
  input  logic [NCH-1:0]    hw_req,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              tc,
  output logic [NCH-1:0]    chan_en
);

  slot_wr_t [NCH-1:0]  slot_wr;
  logic [NCH-1:0]      mask_set, mask_clr, req_set, req_clr;
  logic [NCH-1:0]      step, tc_hit, tc_mask;
  logic [NCH-1:0]      mask_q, req_q;
  logic                byte_ptr;
  logic [ADDR_W-1:0]   slot_addr [NCH];
  logic                tc_q;

  dma_host_decode #(.NCH(NCH)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .slot_wr  (slot_wr),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .req_set  (req_set),
    .req_clr  (req_clr),
    .byte_ptr (byte_ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    assign step[c] = xfer_pulse && (xfer_sel == CH_W'(c));

    dma_chan_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (slot_wr[c]),
      .wr_data    (wr_data),
      .step       (step[c]),
      .cur_addr   (slot_addr[c]),
      .tc_hit     (tc_hit[c]),
      .tc_to_mask (tc_mask[c])
    );
  end

  dma_req_gate #(.NCH(NCH)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .req_set  (req_set),
    .req_clr  (req_clr),
    .tc_mask  (tc_mask),
    .tc_hit   (tc_hit),
    .hw_req   (hw_req),
    .chan_en  (chan_en),
    .mask_q   (mask_q),
    .req_q    (req_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= 1'b0;
    end else begin
      tc_q <= |tc_hit;
    end
  end

  assign tc       = tc_q;
  assign cur_addr = slot_addr[xfer_sel];

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter  int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            xfer_pulse,
  input logic [CH_W-1:0] xfer_sel,
  input logic [15:0]     cur_addr,
  input logic            tc,
  input logic [NCH-1:0]  mask,
  input logic [NCH-1:0]  sw_req,
  input logic            byte_ptr
);

  // R5
  tc_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(xfer_pulse));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && !wr_en) |=> ((xfer_sel != $past(xfer_sel)) || tc
      || (cur_addr == $past(cur_addr) + 16'd1)
      || (cur_addr == $past(cur_addr) - 16'd1)));

  // R7
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mask & ~$past(mask))) |-> (tc || $past(wr_en)));

  // R9
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sw_req) & ~sw_req)) |-> (tc || $past(wr_en)));

  // R2
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ptr != $past(byte_ptr)) |-> $past(wr_en));

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .xfer_pulse (xfer_pulse),
  .xfer_sel   (xfer_sel),
  .cur_addr   (cur_addr),
  .tc         (tc),
  .mask       (mask_q),
  .sw_req     (req_q),
  .byte_ptr   (byte_ptr)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  xfer_sel = '0;
  logic        xfer_pulse = 1'b0;
  logic [3:0]  hw_req = '0;
  logic [15:0] cur_addr;
  logic        tc;
  logic [3:0]  chan_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .xfer_sel(xfer_sel), .xfer_pulse(xfer_pulse),
    .hw_req(hw_req), .cur_addr(cur_addr), .tc(tc), .chan_en(chan_en)
  );

  // behavioural model
  int        m_ba [4], m_ca [4], m_bc [4], m_cc [4];
  bit        m_dn [4], m_au [4];
  bit [3:0]  m_mask, m_req;
  bit        m_ptr, m_tc;
  bit [3:0]  p_mset, p_rclr;
  bit        t_n;
  int        ch;

  function automatic int put_byte(int v, bit hi, logic [7:0] b);
    return hi ? ((v & 'h00FF) | (int'(b) << 8)) : ((v & 'hFF00) | int'(b));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
        m_dn[i] = 0; m_au[i] = 0;
      end
      m_mask = 4'hF; m_req = 0; m_ptr = 0; m_tc = 0;
    end else begin
      t_n = 0; p_mset = 0; p_rclr = 0;
      if (xfer_pulse) begin
        ch = int'(xfer_sel);
        if (m_ca[ch] == 0 && 0) ;
        if (m_cc[ch] == 0) begin
          t_n = 1;
          p_rclr[ch] = 1;
          if (m_au[ch]) begin
            m_ca[ch] = m_ba[ch];
            m_cc[ch] = m_bc[ch];
          end else begin
            m_ca[ch] = (m_ca[ch] + (m_dn[ch] ? -1 : 1)) & 'hFFFF;
            m_cc[ch] = 'hFFFF;
            p_mset[ch] = 1;
          end
        end else begin
          m_ca[ch] = (m_ca[ch] + (m_dn[ch] ? -1 : 1)) & 'hFFFF;
          m_cc[ch] = m_cc[ch] - 1;
        end
      end
      if (wr_en) begin
        if (wr_sel < 4) begin
          m_ba[wr_sel[1:0]] = put_byte(m_ba[wr_sel[1:0]], m_ptr, wr_data);
          m_ca[wr_sel[1:0]] = put_byte(m_ca[wr_sel[1:0]], m_ptr, wr_data);
          m_ptr = !m_ptr;
        end else if (wr_sel < 8) begin
          m_bc[wr_sel[1:0]] = put_byte(m_bc[wr_sel[1:0]], m_ptr, wr_data);
          m_cc[wr_sel[1:0]] = put_byte(m_cc[wr_sel[1:0]], m_ptr, wr_data);
          m_ptr = !m_ptr;
        end else if (wr_sel == 8) begin
          m_dn[wr_data[1:0]] = wr_data[2];
          m_au[wr_data[1:0]] = wr_data[3];
        end else if (wr_sel == 9) begin
          m_mask[wr_data[1:0]] = wr_data[2];
        end else if (wr_sel == 10) begin
          m_req[wr_data[1:0]] = wr_data[2];
        end else if (wr_sel == 11) begin
          m_ptr = 0;
        end else if (wr_sel == 12) begin
          m_mask = wr_data[3:0];
        end
      end
      m_mask = m_mask | p_mset;
      m_req  = m_req & ~p_rclr;
      m_tc   = t_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_addr == 16'(m_ca[xfer_sel]), "R2 R3 R6 R11 cur_addr",
          32'(cur_addr), 32'(m_ca[xfer_sel]));
      chk(tc == m_tc, "R4 R5 tc", 32'(tc), 32'(m_tc));
      chk(chan_en == ((hw_req & ~m_mask) | m_req), "R7 R8 R9 chan_en",
          32'(chan_en), 32'((hw_req & ~m_mask) | m_req));
    end
  end

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_sel = s; wr_data = d; xfer_pulse = 0;
  endtask

  task automatic pulse(input logic [1:0] c);
    @(posedge clk); #1;
    wr_en = 0; xfer_sel = c; xfer_pulse = 1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr_en = 0; xfer_pulse = 0;
  endtask

  task automatic settle();
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hw_req = 4'hF;
    repeat (3) @(negedge clk);
    chk(cur_addr == 0, "R1 cur_addr in reset", 32'(cur_addr), 0);
    chk(tc == 0, "R1 tc in reset", 32'(tc), 0);
    chk(chan_en == 0, "R1 chan_en in reset", 32'(chan_en), 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(chan_en == 0, "R1 masked after reset", 32'(chan_en), 0);

    // channel 0: up, count 2, no reload
    wr(0, 8'h34); wr(0, 8'h12); wr(4, 8'h02); wr(4, 8'h00);
    wr(8, 8'h00); wr(9, 8'h00);
    settle();
    chk(cur_addr == 16'h1234, "R2 address bytes", 32'(cur_addr), 32'h1234);
    chk(chan_en[0] == 1, "R8 unmasked hw request", 32'(chan_en), 1);
    pulse(0); settle();
    chk(cur_addr == 16'h1235, "R3 up step", 32'(cur_addr), 32'h1235);
    chk(tc == 0, "R4 no early tc", 32'(tc), 0);
    pulse(0); idle(); pulse(0); settle();
    chk(tc == 1, "R4 tc on pulse N+1", 32'(tc), 1);
    chk(cur_addr == 16'h1237, "R7 address stepped at tc", 32'(cur_addr), 32'h1237);
    chk(chan_en[0] == 0, "R7 mask set at tc", 32'(chan_en), 0);
    @(negedge clk);
    chk(tc == 0, "R5 tc one cycle", 32'(tc), 0);

    // channel 1: down, count 1, auto reload
    wr(1, 8'h01); wr(1, 8'h00); wr(5, 8'h01); wr(5, 8'h00);
    wr(8, 8'h0D); wr(9, 8'h01);
    pulse(1); settle();
    chk(cur_addr == 16'h0000, "R10 down mode step", 32'(cur_addr), 0);
    pulse(1); settle();
    chk(tc == 1, "R6 tc with reload", 32'(tc), 1);
    chk(cur_addr == 16'h0001, "R6 address reloaded", 32'(cur_addr), 1);
    chk(chan_en[1] == 1, "R6 mask untouched", 32'(chan_en), 2);

    // channel 2: wrap upward
    wr(2, 8'hFF); wr(2, 8'hFF); wr(6, 8'h05); wr(6, 8'h00); wr(8, 8'h02);
    wr(13, 8'hFF);
    pulse(2); settle();
    chk(cur_addr == 16'h0000, "R3 wrap", 32'(cur_addr), 0);

    // pointer clear
    wr(3, 8'hAA); wr(11, 8'h00); wr(3, 8'h78); wr(3, 8'h56);
    @(posedge clk); #1 wr_en = 0; xfer_sel = 3;
    @(negedge clk);
    chk(cur_addr == 16'h5678, "R2 pointer clear", 32'(cur_addr), 32'h5678);

    // software request on masked channel 3
    hw_req = 4'h0;
    wr(7, 8'h00); wr(7, 8'h00); wr(8, 8'h03); wr(10, 8'h07);
    settle();
    chk(chan_en == 4'b1000, "R9 sw request passes mask", 32'(chan_en), 8);
    pulse(3); settle();
    chk(tc == 1, "R9 tc on channel 3", 32'(tc), 1);
    chk(chan_en == 4'b0000, "R9 sw request cleared", 32'(chan_en), 0);

    // mask all
    hw_req = 4'hF;
    wr(12, 8'h05); settle();
    chk(chan_en == 4'b1010, "R8 mask all", 32'(chan_en), 32'hA);

    // collision: pulse and low-byte write on channel 0
    @(posedge clk); #1;
    wr_en = 1; wr_sel = 0; wr_data = 8'h55; xfer_sel = 0; xfer_pulse = 1;
    settle();
    chk(cur_addr == 16'h1255, "R11 host byte over step", 32'(cur_addr), 32'h1255);
    wr(11, 8'h00);

    // random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      hw_req     = 4'($urandom);
      xfer_sel   = 2'($urandom);
      xfer_pulse = ($urandom % 3) == 0;
      wr_en      = ($urandom % 4) == 0;
      wr_sel     = 4'($urandom);
      wr_data    = ($urandom % 2) ? 8'($urandom) : 8'($urandom % 3);
    end
    settle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule